// File: doc/BRIEF.md
# Processor Flag Register and Condition Evaluator

This block keeps the status word of a small integer core. Nine bits have meaning: five arithmetic result flags (carry, parity, half-carry, zero and sign), the overflow flag, and three control bits (interrupt enable, string direction and single-step trap). One reserved bit always reads as one and the other reserved bits read as zero. All updates take effect at the next rising clock edge. Every output is derived combinationally from the stored word.

The block accepts several update sources. An arithmetic unit can write all six result flags at once. Single-bit commands set or clear the interrupt enable and the direction bit, and set, clear or complement the carry. A byte path loads five result flags from the accumulator's upper byte and presents the same five bits back for storing. A full-word restore, used when the word is popped from the stack, writes every defined bit. The restore is the only way the trap bit can change.

Two further outputs serve the rest of the core. A 4-bit condition code selects one test, and `cond_true` gives its result for conditional jumps and conditional sets. From the direction bit and an element size, `idx_step` gives the signed amount by which string instructions move their index registers.

Top module: `flagreg_unit`

## Requirements
- R1: After reset, `flags_out` reads 0x0002. All flags are clear and only reserved bit 1 is set.
- R2: Bits [3:1] of `cond_code` select a base test and bit 0 inverts it. The base tests are: 0 overflow, 1 carry (below), 2 zero (equal), 3 carry OR zero (below-or-equal), 4 sign, 5 parity, 6 sign XOR overflow (less), 7 zero OR (sign XOR overflow) (less-or-equal). So code 7 is above (CF=0 and ZF=0) and code 15 is greater (ZF=0 and SF=OF).
- R3: `cmd` values 1 and 2 set and clear the interrupt enable (bit 9). Values 3 and 4 set and clear the direction bit (bit 10). Value 0 changes nothing.
- R4: `cmd` values 5, 6 and 7 set, clear and complement the carry (bit 0). No other bit changes.
- R5: When `alu_we` is high, the next word takes OF, SF, ZF, AF, PF and CF from `alu_flags` bits 5, 4, 3, 2, 1 and 0. The flags word holds them at bits 11, 7, 6, 4, 2 and 0. In the same cycle this update wins over a carry command and over a byte load.
- R6: When `byte_ld` is high, SF, ZF, AF, PF and CF are loaded from `byte_in` bits 7, 6, 4, 2 and 0. Overflow, direction, interrupt enable and trap are left unchanged.
- R7: `byte_out` carries SF, ZF, AF, PF and CF at bits 7, 6, 4, 2 and 0. Bit 1 is always 1, and bits 5 and 3 are always 0.
- R8: When `restore_we` is high, the next word is `restore_data` masked to the defined bits 0, 2, 4, 6 to 11, with bit 1 forced to 1. The restore wins over every other source in the same cycle.
- R9: The trap bit (bit 8) changes only through a restore. Commands, arithmetic updates and byte loads leave it unchanged.
- R10: `idx_step` is +2^`elem_size` while the direction bit is 0 and -2^`elem_size` in two's complement while it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_we | input | 1 | Write the six arithmetic result flags |
| alu_flags | input | 6 | {OF, SF, ZF, AF, PF, CF} from the arithmetic unit |
| cmd | input | 3 | Single-bit command code (0 = none) |
| byte_ld | input | 1 | Load five flags from the accumulator high byte |
| byte_in | input | 8 | Accumulator high byte |
| restore_we | input | 1 | Full-word restore strobe |
| restore_data | input | 16 | Word being restored |
| cond_code | input | 4 | Condition selector |
| elem_size | input | 2 | log2 of the string element size in bytes |
| flags_out | output | 16 | Current flags word |
| byte_out | output | 8 | Flag byte for storing into the accumulator high byte |
| cond_true | output | 1 | Result of the selected condition |
| idx_step | output | IDX_W | Signed index increment |

## Verification
`flags_out` is a direct copy of the register. A wrong next-state decision therefore shows up at the ports one clock after the stimulus that caused it, and nothing can hide it until the next write. `cond_true`, `byte_out` and `idx_step` are combinational from the same word. A corrupted bit shows in them in the same cycle it shows in `flags_out`, but only when the condition code or element size being applied depends on that bit. The bench therefore sweeps all sixteen codes over flag patterns that separate each operand of the signed and unsigned tests.

// File: rtl/flagreg_pkg.sv
package flagreg_pkg;

    localparam int FLAG_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int ARITH_N = 6;

    // bit positions inside the flags word
    localparam int CF_B  = 0;
    localparam int RSV_B = 1;
    localparam int PF_B  = 2;
    localparam int AF_B  = 4;
    localparam int ZF_B  = 6;
    localparam int SF_B  = 7;
    localparam int TF_B  = 8;
    localparam int IE_B  = 9;
    localparam int DIR_B = 10;
    localparam int OF_B  = 11;

    typedef enum logic [2:0] {
        CMD_NOP     = 3'd0,
        CMD_SET_IE  = 3'd1,
        CMD_CLR_IE  = 3'd2,
        CMD_SET_DIR = 3'd3,
        CMD_CLR_DIR = 3'd4,
        CMD_SET_CY  = 3'd5,
        CMD_CLR_CY  = 3'd6,
        CMD_CPL_CY  = 3'd7
    } ctl_cmd_e;

    typedef struct packed {
        logic ovf;
        logic dir;
        logic ie;
        logic tf;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } flag_s;

    localparam flag_s FLAGS_RESET = '0;

    function automatic flag_s unpack_flags(input logic [FLAG_W-1:0] w);
        flag_s f;
        f.ovf = w[OF_B];
        f.dir = w[DIR_B];
        f.ie  = w[IE_B];
        f.tf  = w[TF_B];
        f.sf  = w[SF_B];
        f.zf  = w[ZF_B];
        f.af  = w[AF_B];
        f.pf  = w[PF_B];
        f.cf  = w[CF_B];
        return f;
    endfunction

    function automatic logic [FLAG_W-1:0] pack_flags(input flag_s f);
        logic [FLAG_W-1:0] w;
        w        = '0;
        w[RSV_B] = 1'b1;
        w[OF_B]  = f.ovf;
        w[DIR_B] = f.dir;
        w[IE_B]  = f.ie;
        w[TF_B]  = f.tf;
        w[SF_B]  = f.sf;
        w[ZF_B]  = f.zf;
        w[AF_B]  = f.af;
        w[PF_B]  = f.pf;
        w[CF_B]  = f.cf;
        return w;
    endfunction

    function automatic logic [BYTE_W-1:0] low_byte(input flag_s f);
        logic [FLAG_W-1:0] w;
        w = pack_flags(f);
        return w[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/flag_state.sv
module flag_state
    import flagreg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alu_we_i,
    input  logic [ARITH_N-1:0]  alu_flags_i,
    input  ctl_cmd_e            cmd_i,
    input  logic                byte_ld_i,
    input  logic [BYTE_W-1:0]   byte_in_i,
    input  logic                restore_we_i,
    input  logic [FLAG_W-1:0]   restore_data_i,
    output flag_s               flags_o
);

    flag_s flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;

        // lowest priority: single-bit commands
        case (cmd_i)
            CMD_SET_IE:  flag_d.ie  = 1'b1;
            CMD_CLR_IE:  flag_d.ie  = 1'b0;
            CMD_SET_DIR: flag_d.dir = 1'b1;
            CMD_CLR_DIR: flag_d.dir = 1'b0;
            CMD_SET_CY:  flag_d.cf  = 1'b1;
            CMD_CLR_CY:  flag_d.cf  = 1'b0;
            CMD_CPL_CY:  flag_d.cf  = ~flag_q.cf;
            default:     ;
        endcase

        // byte load from the accumulator high byte
        if (byte_ld_i) begin
            flag_d.sf = byte_in_i[SF_B];
            flag_d.zf = byte_in_i[ZF_B];
            flag_d.af = byte_in_i[AF_B];
            flag_d.pf = byte_in_i[PF_B];
            flag_d.cf = byte_in_i[CF_B];
        end

        // arithmetic result overrides commands and byte load
        if (alu_we_i) begin
            flag_d.ovf = alu_flags_i[5];
            flag_d.sf  = alu_flags_i[4];
            flag_d.zf  = alu_flags_i[3];
            flag_d.af  = alu_flags_i[2];
            flag_d.pf  = alu_flags_i[1];
            flag_d.cf  = alu_flags_i[0];
        end

        // full-word restore overrides everything
        if (restore_we_i) begin
            flag_d = unpack_flags(restore_data_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= FLAGS_RESET;
        else        flag_q <= flag_d;
    end

    assign flags_o = flag_q;

    // R3: interrupt-enable set command takes effect next cycle
    p_ie_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_SET_IE && !restore_we_i) |=> flag_q.ie);

    // R3: direction clear command takes effect next cycle
    p_dir_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_CLR_DIR && !restore_we_i) |=> !flag_q.dir);

    // R5: arithmetic update lands in full, whatever else arrives
    p_alu_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_we_i && !restore_we_i) |=>
        ({flag_q.ovf, flag_q.sf, flag_q.zf, flag_q.af, flag_q.pf, flag_q.cf}
            == $past(alu_flags_i)));

    // R6: byte load leaves overflow alone
    p_byte_keeps_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ld_i && !alu_we_i && !restore_we_i) |=> $stable(flag_q.ovf));

    // R9: trap bit moves only on restore
    p_trap_only_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !restore_we_i |=> $stable(flag_q.tf));

    // R8: restore loads the masked word
    p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restore_we_i |=> (flag_q == unpack_flags($past(restore_data_i))));

endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import flagreg_pkg::*;
(
    input  flag_s       flags_i,
    input  logic [3:0]  code_i,
    output logic        taken_o
);

    logic sgn_lt;
    logic base;

    always_comb begin
        sgn_lt = flags_i.sf ^ flags_i.ovf;
        case (code_i[3:1])
            3'd0:    base = flags_i.ovf;
            3'd1:    base = flags_i.cf;
            3'd2:    base = flags_i.zf;
            3'd3:    base = flags_i.cf | flags_i.zf;
            3'd4:    base = flags_i.sf;
            3'd5:    base = flags_i.pf;
            3'd6:    base = sgn_lt;
            default: base = flags_i.zf | sgn_lt;
        endcase
        taken_o = base ^ code_i[0];
    end

endmodule

// File: rtl/step_gen.sv
module step_gen #(
    parameter int IDX_W = 16,
    parameter int SZ_W  = 2
) (
    input  logic              dir_i,
    input  logic [SZ_W-1:0]   size_i,
    output logic [IDX_W-1:0]  step_o
);

    localparam int MAX_SHIFT = (1 << SZ_W) - 1;
    localparam logic [IDX_W-1:0] ONE = {{(IDX_W-1){1'b0}}, 1'b1};

    initial begin
        if (IDX_W < MAX_SHIFT + 2) $error("IDX_W too narrow for signed step");
    end

    logic [IDX_W-1:0] mag;

    always_comb begin
        mag    = ONE << size_i;
        step_o = dir_i ? (~mag + ONE) : mag;
    end

endmodule

// File: rtl/flagreg_unit.sv
module flagreg_unit
    import flagreg_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alu_we,
    input  logic [5:0]         alu_flags,
    input  logic [2:0]         cmd,
    input  logic               byte_ld,
    input  logic [7:0]         byte_in,
    input  logic               restore_we,
    input  logic [15:0]        restore_data,
    input  logic [3:0]         cond_code,
    input  logic [1:0]         elem_size,
    output logic [15:0]        flags_out,
    output logic [7:0]         byte_out,
    output logic               cond_true,
    output logic [IDX_W-1:0]   idx_step
);

    flag_s cur;

    flag_state u_state (
        .clk            (clk),
        .rst_n          (rst_n),
        .alu_we_i       (alu_we),
        .alu_flags_i    (alu_flags),
        .cmd_i          (ctl_cmd_e'(cmd)),
        .byte_ld_i      (byte_ld),
        .byte_in_i      (byte_in),
        .restore_we_i   (restore_we),
        .restore_data_i (restore_data),
        .flags_o        (cur)
    );

    cond_eval u_cond (
        .flags_i (cur),
        .code_i  (cond_code),
        .taken_o (cond_true)
    );

    step_gen #(.IDX_W(IDX_W), .SZ_W(2)) u_step (
        .dir_i  (cur.dir),
        .size_i (elem_size),
        .step_o (idx_step)
    );

    assign flags_out = pack_flags(cur);
    assign byte_out  = low_byte(cur);

endmodule

// File: tb/flagreg_unit_test.sv
module flagreg_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alu_we = 1'b0;
    logic [5:0] alu_flags = '0;
    logic [2:0] cmd = '0;
    logic byte_ld = 1'b0;
    logic [7:0] byte_in = '0;
    logic restore_we = 1'b0;
    logic [15:0] restore_data = '0;
    logic [3:0] cond_code = '0;
    logic [1:0] elem_size = '0;
    logic [15:0] flags_out;
    logic [7:0] byte_out;
    logic cond_true;
    logic [IDX_W-1:0] idx_step;

    int checks = 0;
    int fails = 0;
    logic [15:0] model = 16'h0002;

    always #(CLK_PERIOD/2) clk = ~clk;

    flagreg_unit #(.IDX_W(IDX_W)) uut (
        .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_flags(alu_flags),
        .cmd(cmd), .byte_ld(byte_ld), .byte_in(byte_in),
        .restore_we(restore_we), .restore_data(restore_data),
        .cond_code(cond_code), .elem_size(elem_size),
        .flags_out(flags_out), .byte_out(byte_out),
        .cond_true(cond_true), .idx_step(idx_step)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model written from the requirements
    function automatic logic [15:0] next_model(
        input logic [15:0] m, input logic aw, input logic [5:0] af,
        input logic [2:0] c, input logic bl, input logic [7:0] bi,
        input logic rw, input logic [15:0] rd);
        logic [15:0] n;
        n = m;
        case (c)
            3'd1: n[9]  = 1'b1;
            3'd2: n[9]  = 1'b0;
            3'd3: n[10] = 1'b1;
            3'd4: n[10] = 1'b0;
            3'd5: n[0]  = 1'b1;
            3'd6: n[0]  = 1'b0;
            3'd7: n[0]  = ~m[0];
            default: ;
        endcase
        if (bl) begin
            n[7] = bi[7]; n[6] = bi[6]; n[4] = bi[4]; n[2] = bi[2]; n[0] = bi[0];
        end
        if (aw) begin
            n[11] = af[5]; n[7] = af[4]; n[6] = af[3];
            n[4]  = af[2]; n[2] = af[1]; n[0] = af[0];
        end
        if (rw) n = (rd & 16'h0FD5) | 16'h0002;
        return n;
    endfunction

    function automatic logic exp_cond(input logic [15:0] m, input logic [3:0] cc);
        logic c, p, z, s, o, b;
        c = m[0]; p = m[2]; z = m[6]; s = m[7]; o = m[11];
        case (cc[3:1])
            3'd0: b = o;
            3'd1: b = c;
            3'd2: b = z;
            3'd3: b = c | z;
            3'd4: b = s;
            3'd5: b = p;
            3'd6: b = (s != o);
            default: b = z | (s != o);
        endcase
        return cc[0] ? ~b : b;
    endfunction

    task automatic cycle(input logic aw, input logic [5:0] af, input logic [2:0] c,
                         input logic bl, input logic [7:0] bi,
                         input logic rw, input logic [15:0] rd);
        alu_we = aw; alu_flags = af; cmd = c; byte_ld = bl; byte_in = bi;
        restore_we = rw; restore_data = rd;
        @(posedge clk); #1;
        alu_we = 0; cmd = 0; byte_ld = 0; restore_we = 0;
        model = next_model(model, aw, af, c, bl, bi, rw, rd);
    endtask

    task automatic t_reset();
        chk("R1 reset word", 32'(flags_out), 32'h0002);
        chk("R7 reset byte", 32'(byte_out), 32'h02);
    endtask

    task automatic t_commands();
        for (int c = 1; c <= 4; c++) begin
            cycle(0, '0, 3'(c), 0, '0, 0, '0);
            chk("R3 ie/dir command", 32'(flags_out), 32'(model));
        end
        cycle(0, '0, 3'd1, 0, '0, 0, '0);
        chk("R3 ie set", 32'(flags_out[9]), 32'h1);
        cycle(0, '0, 3'd3, 0, '0, 0, '0);
        chk("R3 dir set", 32'(flags_out), 32'(model));
        cycle(0, '0, 3'd5, 0, '0, 0, '0);
        chk("R4 carry set", 32'(flags_out), 32'(model));
        cycle(0, '0, 3'd7, 0, '0, 0, '0);
        chk("R4 carry complement to 0", 32'(flags_out), 32'(model));
        cycle(0, '0, 3'd7, 0, '0, 0, '0);
        chk("R4 carry complement to 1", 32'(flags_out), 32'(model));
        cycle(0, '0, 3'd6, 0, '0, 0, '0);
        chk("R4 carry clear", 32'(flags_out), 32'(model));
        cycle(0, '0, 3'd0, 0, '0, 0, '0);
        chk("R3 nop", 32'(flags_out), 32'(model));
        chk("R9 trap after commands", 32'(flags_out[8]), 32'h0);
    endtask

    task automatic t_alu();
        cycle(1, 6'b101010, 0, 0, '0, 0, '0);
        chk("R5 alu pattern A", 32'(flags_out), 32'(model));
        cycle(1, 6'b010101, 0, 0, '0, 0, '0);
        chk("R5 alu pattern B", 32'(flags_out), 32'(model));
        // carry command and byte load collide with the arithmetic write
        cycle(1, 6'b100000, 3'd5, 1, 8'hFF, 0, '0);
        chk("R5 alu wins collision", 32'(flags_out), 32'(model));
        chk("R5 carry stays clear", 32'(flags_out[0]), 32'h0);
    endtask

    task automatic t_byte();
        cycle(1, 6'b100000, 0, 0, '0, 0, '0);
        cycle(0, '0, 0, 1, 8'hFF, 0, '0);
        chk("R6 byte load all ones", 32'(flags_out), 32'(model));
        chk("R6 overflow kept", 32'(flags_out[11]), 32'h1);
        chk("R7 byte store fixed bits", 32'(byte_out), 32'hD7);
        cycle(0, '0, 0, 1, 8'h00, 0, '0);
        chk("R6 byte load zeros", 32'(flags_out), 32'(model));
        chk("R7 byte store zeros", 32'(byte_out), 32'h02);
        cycle(0, '0, 0, 1, 8'h41, 0, '0);
        chk("R7 byte store zf cf", 32'(byte_out), 32'h43);
    endtask

    task automatic t_restore();
        cycle(0, '0, 0, 0, '0, 1, 16'hFFFF);
        chk("R8 restore all ones", 32'(flags_out), 32'h0FD7);
        chk("R9 trap via restore", 32'(flags_out[8]), 32'h1);
        cycle(0, '0, 3'd2, 0, '0, 0, '0);
        cycle(1, 6'h00, 3'd4, 1, 8'h00, 0, '0);
        chk("R9 trap held", 32'(flags_out[8]), 32'h1);
        chk("R9 word after updates", 32'(flags_out), 32'(model));
        cycle(1, 6'h3F, 3'd1, 1, 8'hFF, 1, 16'h0000);
        chk("R8 restore wins", 32'(flags_out), 32'h0002);
    endtask

    task automatic t_cond();
        logic [15:0] pats [8] = '{16'h0000, 16'h0001, 16'h0040, 16'h0080,
                                  16'h0800, 16'h0880, 16'h0004, 16'h08C5};
        foreach (pats[i]) begin
            cycle(0, '0, 0, 0, '0, 1, pats[i]);
            for (int cc = 0; cc < 16; cc++) begin
                cond_code = 4'(cc);
                #1;
                chk($sformatf("R2 code %0d pattern %h", cc, pats[i]),
                    32'(cond_true), 32'(exp_cond(model, 4'(cc))));
            end
        end
    endtask

    task automatic t_step();
        for (int d = 0; d < 2; d++) begin
            cycle(0, '0, d ? 3'd3 : 3'd4, 0, '0, 0, '0);
            for (int s = 0; s < 4; s++) begin
                logic [IDX_W-1:0] e;
                elem_size = 2'(s);
                #1;
                e = IDX_W'(1) << s;
                if (d != 0) e = -e;
                chk($sformatf("R10 step dir %0d size %0d", d, s), 32'(idx_step), 32'(e));
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_commands();
        t_alu();
        t_byte();
        t_restore();
        t_cond();
        t_step();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule